// File: doc/BRIEF.md
# Iterative Multiply/Divide Execution Unit

This unit carries out the eight multiply, divide and remainder operations of the 32-bit RISC-V M extension, apart from the core's single-cycle ALU. The core pulses `start` with an operation code and two source operands. The unit captures them on that edge and raises `busy`. When the result is ready it pulses `done` for one cycle with the 32-bit value on `result`. The core's datapath holds its state while `busy` is high.

Products come from a registered full-width multiplier. Its stage count is a parameter, so the multiply latency is fixed. Quotients and remainders come from a restoring shift-subtract loop over the operand magnitudes, one bit per cycle. The signs are applied in a final cycle. Division by zero and signed overflow give the results the ISA defines, and they raise no trap. The block runs on one clock with a synchronous active-high reset.

Top module: `muldiv_unit`

## Requirements
- R1: The operation code on `op` uses this encoding: 0 MUL, 1 MULH, 2 MULHSU, 3 MULHU, 4 DIV, 5 DIVU, 6 REM, 7 REMU. When `start` is high at a rising edge while `busy` is low, the unit captures `op`, `srcA` and `srcB`, and `busy` is high in the following cycle.
- R2: MUL returns the low 32 bits of srcA×srcB.
- R3: MULH, MULHSU and MULHU return the upper 32 bits of the 64-bit product. MULH treats both operands as signed. MULHSU treats srcA as signed and srcB as unsigned. MULHU treats both as unsigned.
- R4: DIVU and REMU return the unsigned quotient and remainder of srcA divided by srcB.
- R5: DIV and REM divide signed operands. The quotient rounds toward zero, and the remainder takes the sign of the dividend.
- R6: When srcB is zero, DIV and DIVU return 0xFFFFFFFF, and REM and REMU return srcA.
- R7: DIV with srcA = 0x80000000 and srcB = 0xFFFFFFFF returns 0x80000000, and REM with the same operands returns 0.
- R8: `done` rises MUL_STAGES+1 cycles after the accepting edge for the four multiply codes (2 with defaults). It rises WIDTH+1 cycles after that edge for the four divide codes (33 with defaults).
- R9: `done` is high for exactly one cycle, and `busy` is low while `done` is high. `result` keeps its value until the next `done`.
- R10: A `start` that arrives while `busy` is high is ignored. The operation in flight returns its own result, and no further operation begins.
- R11: Reset drives `busy`, `done` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted only while idle |
| op | input | 3 | Operation code (encoding in R1) |
| srcA | input | 32 | First operand (multiplicand or dividend) |
| srcB | input | 32 | Second operand (multiplier or divisor) |
| busy | output | 1 | High from the cycle after acceptance until the result cycle |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 32 | Result of the last completed operation |

## Verification
Faults in the control counter appear at the ports within one operation. `done` then arrives a cycle early or late, or `busy` stays high, so the bench measures the latency of every operation it issues. A faulty partial remainder or sign flag corrupts only the quotient or remainder of that operation, and the error shows on `result` at the next `done` pulse. The bench therefore compares every result against a reference model, and it mixes random operands with the boundary values that make the sign and special-case paths matter. An operand latch that accepts a start while busy shows as a wrong result or as an extra `busy` period after `done`.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  // Operation codes; the low bits follow the instruction funct3 field.
  typedef enum logic [2:0] {
    OP_MUL    = 3'd0,
    OP_MULH   = 3'd1,
    OP_MULHSU = 3'd2,
    OP_MULHU  = 3'd3,
    OP_DIV    = 3'd4,
    OP_DIVU   = 3'd5,
    OP_REM    = 3'd6,
    OP_REMU   = 3'd7
  } mdOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;     // capture operands and prepare magnitudes
    logic mulStep;  // clock the product register
    logic divStep;  // one restoring shift-subtract iteration
    logic finish;   // form and register the final result
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int MUL_STAGES = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      isDiv,
  output mdStrobe_t strb,
  output logic      busy,
  output logic      done
);

  localparam int CNT_MAX = (WIDTH > MUL_STAGES) ? WIDTH : MUL_STAGES;
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;

  typedef enum logic [1:0] {S_IDLE, S_MULW, S_DIVW, S_FIN} ctrlState_e;

  ctrlState_e       state;
  logic [CNT_W-1:0] cnt;
  logic             doneReg;

  always_comb begin
    strb.load    = start && (state == S_IDLE);
    strb.mulStep = (state == S_MULW);
    strb.divStep = (state == S_DIVW);
    strb.finish  = (state == S_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= (state == S_FIN);
      case (state)
        S_IDLE: begin
          if (start) begin
            if (isDiv) begin
              cnt   <= CNT_W'(WIDTH - 1);
              state <= S_DIVW;
            end else begin
              cnt   <= CNT_W'(MUL_STAGES - 1);
              state <= S_MULW;
            end
          end
        end
        S_MULW, S_DIVW: begin
          if (cnt == '0) state <= S_FIN;
          else           cnt   <= cnt - 1'b1;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneReg;

  // R9: single-cycle completion pulse, never overlapping busy
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R1: an accepted start makes the unit busy on the next cycle
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R8/R10: a running operation cannot be cut short by new requests
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && state != S_FIN) |=> busy);

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  mdStrobe_t        strb,
  input  mdOp_e            op,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] result
);

  localparam int PW = 2 * WIDTH;

  mdOp_e            opReg;
  logic [WIDTH-1:0] aReg, bReg;
  logic [PW-1:0]    prodReg;
  logic [WIDTH-1:0] remReg, quoReg, divisorMag;
  logic             negQ, negR, divZero;
  logic [WIDTH-1:0] resultReg;

  // Operand sign handling at acceptance
  logic signedDiv, aNeg, bNeg;
  always_comb begin
    signedDiv = (op == OP_DIV) || (op == OP_REM);
    aNeg      = signedDiv && srcA[WIDTH-1];
    bNeg      = signedDiv && srcB[WIDTH-1];
  end

  // Multiplier operands, extended to full product width
  logic          aSigned, bSigned;
  logic [PW-1:0] aExt, bExt, fullProd;
  always_comb begin
    aSigned  = (opReg == OP_MULH) || (opReg == OP_MULHSU);
    bSigned  = (opReg == OP_MULH);
    aExt     = {{WIDTH{aSigned && aReg[WIDTH-1]}}, aReg};
    bExt     = {{WIDTH{bSigned && bReg[WIDTH-1]}}, bReg};
    fullProd = aExt * bExt;
  end

  // One restoring iteration
  logic [WIDTH:0] shifted, diff;
  always_comb begin
    shifted = {remReg, quoReg[WIDTH-1]};
    diff    = shifted - {1'b0, divisorMag};
  end

  // Final result selection
  logic [WIDTH-1:0] finalVal;
  always_comb begin
    case (opReg)
      OP_MUL:                      finalVal = prodReg[WIDTH-1:0];
      OP_MULH, OP_MULHSU, OP_MULHU: finalVal = prodReg[PW-1:WIDTH];
      OP_DIV, OP_DIVU:             finalVal = divZero ? '1 : (negQ ? -quoReg : quoReg);
      default:                     finalVal = negR ? -remReg : remReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opReg      <= OP_MUL;
      aReg       <= '0;
      bReg       <= '0;
      prodReg    <= '0;
      remReg     <= '0;
      quoReg     <= '0;
      divisorMag <= '0;
      negQ       <= 1'b0;
      negR       <= 1'b0;
      divZero    <= 1'b0;
      resultReg  <= '0;
    end else begin
      if (strb.load) begin
        opReg      <= op;
        aReg       <= srcA;
        bReg       <= srcB;
        remReg     <= '0;
        quoReg     <= aNeg ? -srcA : srcA;
        divisorMag <= bNeg ? -srcB : srcB;
        negQ       <= aNeg ^ bNeg;
        negR       <= aNeg;
        divZero    <= (srcB == '0);
      end
      if (strb.mulStep) prodReg <= fullProd;
      if (strb.divStep) begin
        quoReg <= {quoReg[WIDTH-2:0], ~diff[WIDTH]};
        remReg <= diff[WIDTH] ? shifted[WIDTH-1:0] : diff[WIDTH-1:0];
      end
      if (strb.finish) resultReg <= finalVal;
    end
  end

  assign result = resultReg;

  // R4: the partial remainder stays below the divisor after every step
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.divStep && divisorMag != '0) |=> (remReg < divisorMag));
  // R6: a zero divisor yields an all-ones quotient
  assert_div_by_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (strb.finish && divZero && (opReg == OP_DIV || opReg == OP_DIVU))
      |=> (resultReg == '1));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int MUL_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  mdStrobe_t strb;

  muldiv_ctrl #(.WIDTH(WIDTH), .MUL_STAGES(MUL_STAGES)) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .isDiv (op[2]),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  muldiv_dp #(.WIDTH(WIDTH)) uDp (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .op     (mdOp_e'(op)),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (result)
  );

endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;

  localparam int MUL_LAT = 2;   // R8 with default stages
  localparam int DIV_LAT = 33;  // R8 with default width

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  opIn = 3'd0;
  logic [31:0] aIn = '0, bIn = '0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  muldiv_unit dut (
    .clk(clk), .rst(rst), .start(start), .op(opIn),
    .srcA(aIn), .srcB(bIn), .busy(busy), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] sa, sb, ua, ub, p;
    int qa, qb;
    sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
    ua = {32'h0, a};       ub = {32'h0, b};
    qa = a; qb = b;
    case (o)
      3'd0: begin p = ua * ub; return p[31:0]; end
      3'd1: begin p = sa * sb; return p[63:32]; end
      3'd2: begin p = sa * ub; return p[63:32]; end
      3'd3: begin p = ua * ub; return p[63:32]; end
      3'd4: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return 32'(qa / qb);
      end
      3'd5: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'd6: begin
        if (b == 0) return a;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
        return 32'(qa % qb);
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1, 3'd2, 3'd3: return "R3";
      3'd5, 3'd7: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic runOp(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input bit inject, input string tag);
    logic [31:0] exp;
    int expLat, k;
    exp    = model(o, a, b);
    expLat = o[2] ? DIV_LAT : MUL_LAT;
    @(negedge clk);
    start = 1'b1; opIn = o; aIn = a; bIn = b;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after accept", 32'(busy), 32'd1);
    if (inject) begin
      opIn = ~o; aIn = ~a; bIn = b + 32'd1;   // R10: start while busy
    end else start = 1'b0;
    k = 1;
    while (!done && k < 80) begin
      @(negedge clk);
      start = 1'b0;
      k++;
    end
    chk(k - 1 == expLat, "R8 latency", 32'(k - 1), 32'(expLat));
    chk(result == exp, tag, result, exp);
    chk(busy == 1'b0, "R9 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", 32'(done), 32'd0);
    chk(result == exp, "R9 result held", result, exp);
    if (inject) begin
      chk(busy == 1'b0, "R10 no extra operation", 32'(busy), 32'd0);
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R10 stays idle", {30'd0, busy, done}, 32'd0);
    end
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] sp [5];
    sp[0] = 32'h0; sp[1] = 32'h1; sp[2] = 32'hFFFF_FFFF;
    sp[3] = 32'h8000_0000; sp[4] = 32'h7FFF_FFFF;
    if (($urandom % 4) == 0) return sp[$urandom % 5];
    if (($urandom % 3) == 0) return $urandom % 64;
    return $urandom;
  endfunction

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy == 0 && done == 0, "R11 reset flags", {30'd0, busy, done}, 32'd0);
    chk(result == 0, "R11 reset result", result, 32'd0);
    rst = 1'b0;

    // Directed corner cases
    runOp(3'd0, 32'd7, 32'd6, 0, "R2");
    runOp(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R2");
    runOp(3'd1, 32'h8000_0000, 32'h8000_0000, 0, "R3");
    runOp(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
    runOp(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
    runOp(3'd5, 32'd100, 32'd7, 0, "R4");
    runOp(3'd7, 32'hFFFF_FFFF, 32'd10, 0, "R4");
    runOp(3'd4, -32'sd7, 32'd2, 0, "R5");
    runOp(3'd6, -32'sd7, 32'd2, 0, "R5");
    runOp(3'd6, 32'd7, -32'sd2, 0, "R5");
    runOp(3'd4, 32'h1234_5678, 32'd0, 0, "R6");
    runOp(3'd5, 32'h1234_5678, 32'd0, 0, "R6");
    runOp(3'd6, 32'h8765_4321, 32'd0, 0, "R6");
    runOp(3'd7, 32'h8765_4321, 32'd0, 0, "R6");
    runOp(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R7");
    runOp(3'd6, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R7");
    runOp(3'd1, 32'd3, 32'd5, 1, "R10 mul");
    runOp(3'd4, 32'd1000, 32'd3, 1, "R10 div");

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic [2:0] o;
      o = 3'($urandom % 8);
      runOp(o, pick(), pick(), (i % 7) == 3, tagFor(o));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule